// File: doc/BRIEF.md
# Motor Drive State Supervisor

This block is the digital supervisor that sits beside a PWM motor predriver and decides whether the gate drive may run. It takes a command-present level and, when the input path needs it, a keep-alive tick. It also takes undervoltage and overvoltage flags that have already been through their hysteresis comparators, and an overcurrent flag that is valid on each strobe from the PWM generator. From these it keeps one of three operating states: sleep, run and fault. It drives a gate-enable, a one-cycle soft-start request and a 2-bit state code. Gate drive is allowed only in run.

Overcurrent is handled as a sequence. A counter tracks consecutive PWM pulses that carry the overcurrent flag. When it reaches the trip count, the block holds the gate off for a fixed number of pulses and then makes one automatic restart. If overcurrent trips again before the restart has proved itself clean, the block latches into fault. Only removing the command, which passes through sleep, releases the latch. Overvoltage gives a fault that recovers by itself. Undervoltage or a missing command sends the block to sleep. All flags are plain level inputs, and there is no handshake at the block's edge.

Top module: `motor_supervisor`

## Requirements
- R1: While rst_n is low at a clock edge, the block enters sleep: state_code 00, gate_en 0, soft_start 0, and all counters and latches cleared.
- R2: From sleep, with a valid command and neither uv_flag nor ov_flag set, the next edge enters run. In run, state_code is 01 and gate_en is 1. Every entry into run raises soft_start for exactly one cycle, the first cycle in run.
- R3: When the command is invalid or uv_flag is 1 at an edge, the next state is sleep (00, gate_en 0), from any state. This also clears the overcurrent lockout and the retry flag.
- R4: With a valid command, ov_flag at 1 in sleep or run gives fault (state_code 10, gate_en 0) at the next edge. An overvoltage fault returns to run once ov_flag is 0.
- R5: With auto_mode at 1, the command is valid only while a keep_tick was sampled within the last KEEPALIVE_CLKS clocks. After the edge that samples a tick, the block stays in run for KEEPALIVE_CLKS edges and falls to sleep on the edge after that. With auto_mode at 0, ticks have no effect.
- R6: In run, a pulse_stb with oc_flag at 1 adds one to the overcurrent count, and a pulse_stb with oc_flag at 0 resets the count to zero. The OC_PULSES-th consecutive overcurrent pulse moves the block to fault (10) at that edge.
- R7: After an overcurrent trip, the fault holds for exactly HOLD_PULSES strobes. The edge that samples the last of these strobes returns the block to run with a soft_start pulse.
- R8: A trip that happens while the retry flag is set latches the fault. The block then stays at 10 however many strobes follow, and only leaves through sleep (R3).
- R9: The retry flag is set by a trip. It clears after OC_PULSES consecutive overcurrent-free strobes in run, after which the next trip again gives a timed hold and not a latch.
- R10: gate_en is 1 exactly when state_code is 01. state_code never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_present | input | 1 | Input command applied |
| auto_mode | input | 1 | 1: command also needs keep-alive ticks |
| keep_tick | input | 1 | Keep-alive pulse from the input conditioner |
| uv_flag | input | 1 | Supply below the undervoltage threshold (hysteresed) |
| ov_flag | input | 1 | Supply above the overvoltage threshold (hysteresed) |
| pulse_stb | input | 1 | One cycle per PWM period |
| oc_flag | input | 1 | Overcurrent seen in this PWM pulse, valid with pulse_stb |
| gate_en | output | 1 | Gate drive permitted |
| soft_start | output | 1 | One-cycle request to restart the soft-start ramp |
| state_code | output | 2 | 00 sleep, 01 run, 10 fault |

## Verification
The overcurrent path is swept with every run of 1 to OC_PULSES-1 overcurrent pulses followed by a clean pulse. This shows that the count resets and that the trip lands on the exact pulse. The hold is then counted strobe by strobe to pin down the restart edge. A back-to-back second trip is set against a second trip that follows a full clean window, which separates the latched fault from the retried one. Supply flags, command removal and keep-alive expiry are each applied from run and from fault, and the keep-alive case is timed to the exact edge of expiry.

// File: rtl/motor_sup_pkg.sv
package motor_sup_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'b00,
    ST_RUN   = 2'b01,
    ST_FAULT = 2'b10
  } sup_state_t;

  typedef enum logic [1:0] {
    FK_OV   = 2'b00,
    FK_HOLD = 2'b01,
    FK_LOCK = 2'b10
  } fault_kind_t;
endpackage

// File: rtl/sup_keepalive.sv
module sup_keepalive #(
  parameter int LIMIT = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic alive
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        age_q <= LIM;
    else if (tick)     age_q <= '0;
    else if (age_q != LIM) age_q <= age_q + 1'b1;
  end

  assign alive = (age_q != LIM);

  p_age_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    age_q <= LIM);
  p_tick_alive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> alive);
endmodule

// File: rtl/sup_oc_track.sv
module sup_oc_track #(
  parameter int OC_PULSES = 64000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_all,
  input  logic run_active,
  input  logic pulse_stb,
  input  logic oc_flag,
  output logic trip,
  output logic retried
);
  localparam int CW = $clog2(OC_PULSES + 1);
  localparam logic [CW-1:0] LAST = CW'(OC_PULSES - 1);

  logic [CW-1:0] oc_cnt_q;
  logic [CW-1:0] clean_cnt_q;
  logic          retried_q;
  logic          oc_pulse, clean_pulse, clean_done;

  assign oc_pulse    = run_active && pulse_stb && oc_flag;
  assign clean_pulse = run_active && pulse_stb && !oc_flag;
  assign trip        = oc_pulse && (oc_cnt_q == LAST);
  assign clean_done  = clean_pulse && (clean_cnt_q == LAST);
  assign retried     = retried_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_active) begin
      oc_cnt_q    <= '0;
      clean_cnt_q <= '0;
    end else if (oc_pulse) begin
      oc_cnt_q    <= trip ? '0 : oc_cnt_q + 1'b1;
      clean_cnt_q <= '0;
    end else if (clean_pulse) begin
      oc_cnt_q    <= '0;
      clean_cnt_q <= clean_done ? '0 : clean_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) retried_q <= 1'b0;
    else if (trip)         retried_q <= 1'b1;
    else if (clean_done)   retried_q <= 1'b0;
  end

  p_oc_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oc_cnt_q <= LAST);
  p_clean_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clean_pulse |=> oc_cnt_q == '0);
  p_trip_sets_retry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !clr_all) |=> retried_q);
endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
  parameter int HOLD_PULSES = 64000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic pulse_stb,
  output logic done
);
  localparam int CW = $clog2(HOLD_PULSES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_PULSES - 1);

  logic [CW-1:0] cnt_q;

  assign done = active && pulse_stb && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !active || done) cnt_q <= '0;
    else if (pulse_stb)            cnt_q <= cnt_q + 1'b1;
  end

  p_hold_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/motor_supervisor.sv
module motor_supervisor
  import motor_sup_pkg::*;
#(
  parameter int OC_PULSES      = 64000,
  parameter int HOLD_PULSES    = 64000,
  parameter int KEEPALIVE_CLKS = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_present,
  input  logic       auto_mode,
  input  logic       keep_tick,
  input  logic       uv_flag,
  input  logic       ov_flag,
  input  logic       pulse_stb,
  input  logic       oc_flag,
  output logic       gate_en,
  output logic       soft_start,
  output logic [1:0] state_code
);
  sup_state_t  state_q, state_d;
  fault_kind_t kind_q, kind_d;
  logic        gate_q, soft_q;
  logic        alive, cmd_ok, trip, retried, hold_done;
  logic        in_run, in_sleep, in_hold;

  assign in_run   = (state_q == ST_RUN);
  assign in_sleep = (state_q == ST_SLEEP);
  assign in_hold  = (state_q == ST_FAULT) && (kind_q == FK_HOLD);

  sup_keepalive #(.LIMIT(KEEPALIVE_CLKS)) ka_i (
    .clk(clk), .rst_n(rst_n), .tick(keep_tick), .alive(alive)
  );

  sup_oc_track #(.OC_PULSES(OC_PULSES)) oc_i (
    .clk(clk), .rst_n(rst_n), .clr_all(in_sleep), .run_active(in_run),
    .pulse_stb(pulse_stb), .oc_flag(oc_flag), .trip(trip), .retried(retried)
  );

  sup_hold_timer #(.HOLD_PULSES(HOLD_PULSES)) hold_i (
    .clk(clk), .rst_n(rst_n), .active(in_hold), .pulse_stb(pulse_stb),
    .done(hold_done)
  );

  assign cmd_ok = cmd_present && (!auto_mode || alive);

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    if (!cmd_ok || uv_flag) begin
      state_d = ST_SLEEP;
    end else begin
      unique case (state_q)
        ST_SLEEP: begin
          if (ov_flag) begin
            state_d = ST_FAULT;
            kind_d  = FK_OV;
          end else begin
            state_d = ST_RUN;
          end
        end
        ST_RUN: begin
          if (ov_flag) begin
            state_d = ST_FAULT;
            kind_d  = FK_OV;
          end else if (trip) begin
            state_d = ST_FAULT;
            kind_d  = retried ? FK_LOCK : FK_HOLD;
          end
        end
        ST_FAULT: begin
          unique case (kind_q)
            FK_OV:   if (!ov_flag) state_d = ST_RUN;
            FK_HOLD: begin
              if (hold_done) begin
                if (ov_flag) kind_d = FK_OV;
                else         state_d = ST_RUN;
              end
            end
            default: state_d = ST_FAULT;
          endcase
        end
        default: state_d = ST_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SLEEP;
      kind_q  <= FK_OV;
      gate_q  <= 1'b0;
      soft_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      gate_q  <= (state_d == ST_RUN);
      soft_q  <= (state_d == ST_RUN) && (state_q != ST_RUN);
    end
  end

  assign gate_en    = gate_q;
  assign soft_start = soft_q;
  assign state_code = state_q;

  p_gate_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q == (state_q == ST_RUN));
  p_no_code3_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state_code != 2'b11);
  p_soft_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q |-> (state_q == ST_RUN));
  p_soft_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q |=> !soft_q);
  p_uv_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> state_q == ST_SLEEP);
  p_ov_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag && cmd_ok && !uv_flag && state_q == ST_RUN) |=> state_q == ST_FAULT);
  p_lock_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT && kind_q == FK_LOCK && cmd_ok && !uv_flag)
      |=> (state_q == ST_FAULT && kind_q == FK_LOCK));
endmodule

// File: tb/motor_supervisor_tb_top.sv
module motor_supervisor_tb_top;
  localparam int OCP = 4;
  localparam int HLD = 5;
  localparam int KAL = 8;

  logic clk = 1'b0;
  logic rst_n, cmd_present, auto_mode, keep_tick, uv_flag, ov_flag;
  logic pulse_stb, oc_flag;
  logic gate_en, soft_start;
  logic [1:0] state_code;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  motor_supervisor #(.OC_PULSES(OCP), .HOLD_PULSES(HLD), .KEEPALIVE_CLKS(KAL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_present(cmd_present), .auto_mode(auto_mode),
    .keep_tick(keep_tick), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .pulse_stb(pulse_stb), .oc_flag(oc_flag), .gate_en(gate_en),
    .soft_start(soft_start), .state_code(state_code)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic oc);
    pulse_stb = 1'b1;
    oc_flag   = oc;
    step();
    pulse_stb = 1'b0;
    oc_flag   = 1'b0;
  endtask

  task automatic chk(input string req, input logic [1:0] exp_st, input logic exp_soft);
    logic exp_gate;
    exp_gate = (exp_st == 2'b01);
    total++;
    if (state_code !== exp_st || gate_en !== exp_gate || soft_start !== exp_soft) begin
      bad++;
      $display("FAIL %s: state=%b gate=%b soft=%b expected state=%b gate=%b soft=%b",
               req, state_code, gate_en, soft_start, exp_st, exp_gate, exp_soft);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_present = 1'b0; auto_mode = 1'b0; keep_tick = 1'b0;
    uv_flag = 1'b0; ov_flag = 1'b0; pulse_stb = 1'b0; oc_flag = 1'b0;
    @(negedge clk);
    cmd_present = 1'b1;
    step(); step();
    chk("R1 reset", 2'b00, 1'b0);
    rst_n = 1'b1;

    // R2 entry into run with soft start
    step();
    chk("R2 enter run", 2'b01, 1'b1);
    step();
    chk("R2 soft one cycle", 2'b01, 1'b0);

    // R6 sweep: k overcurrent pulses then a clean one never trips
    for (int k = 1; k < OCP; k++) begin
      for (int j = 0; j < k; j++) pulse(1'b1);
      chk("R6 below count", 2'b01, 1'b0);
      pulse(1'b0);
      chk("R6 clean resets", 2'b01, 1'b0);
    end
    for (int j = 0; j < OCP - 1; j++) pulse(1'b1);
    chk("R6 one short of trip", 2'b01, 1'b0);
    pulse(1'b1);
    chk("R6 trip", 2'b10, 1'b0);

    // R7 timed hold
    for (int j = 0; j < HLD - 1; j++) begin
      pulse(1'b0);
      chk("R7 holding", 2'b10, 1'b0);
    end
    pulse(1'b0);
    chk("R7 restart", 2'b01, 1'b1);
    step();
    chk("R7 soft cleared", 2'b01, 1'b0);

    // R8 second consecutive trip latches
    for (int j = 0; j < OCP; j++) pulse(1'b1);
    chk("R8 second trip", 2'b10, 1'b0);
    for (int j = 0; j < 3 * HLD; j++) pulse(1'b0);
    chk("R8 latched", 2'b10, 1'b0);
    cmd_present = 1'b0;
    step();
    chk("R3 command removed", 2'b00, 1'b0);
    cmd_present = 1'b1;
    step();
    chk("R8 release via sleep", 2'b01, 1'b1);

    // R9 retry clears after a clean window
    for (int j = 0; j < OCP; j++) pulse(1'b1);
    chk("R9 first trip after sleep", 2'b10, 1'b0);
    for (int j = 0; j < HLD; j++) pulse(1'b0);
    chk("R9 restart", 2'b01, 1'b1);
    for (int j = 0; j < OCP; j++) pulse(1'b0);
    for (int j = 0; j < OCP; j++) pulse(1'b1);
    chk("R9 trip after clean window", 2'b10, 1'b0);
    for (int j = 0; j < HLD; j++) pulse(1'b0);
    chk("R9 held not latched", 2'b01, 1'b1);

    // R4 overvoltage
    ov_flag = 1'b1;
    step();
    chk("R4 ov fault", 2'b10, 1'b0);
    step();
    chk("R4 ov stays", 2'b10, 1'b0);
    ov_flag = 1'b0;
    step();
    chk("R4 ov recover", 2'b01, 1'b1);

    // R3 undervoltage from run and from fault
    uv_flag = 1'b1;
    step();
    chk("R3 uv sleep", 2'b00, 1'b0);
    uv_flag = 1'b0;
    step();
    chk("R3 uv recover", 2'b01, 1'b1);
    for (int j = 0; j < OCP; j++) pulse(1'b1);
    chk("R3 fault before uv", 2'b10, 1'b0);
    uv_flag = 1'b1;
    step();
    chk("R3 uv from fault", 2'b00, 1'b0);

    // R5 keep-alive
    auto_mode = 1'b1;
    uv_flag = 1'b0;
    step(); step(); step();
    chk("R5 no tick stays asleep", 2'b00, 1'b0);
    keep_tick = 1'b1;
    step();
    keep_tick = 1'b0;
    step();
    chk("R5 tick wakes", 2'b01, 1'b1);
    for (int j = 0; j < 5; j++) begin
      keep_tick = 1'b1;
      step();
      keep_tick = 1'b0;
      step(); step();
      chk("R5 regular ticks", 2'b01, 1'b0);
    end
    keep_tick = 1'b1;
    step();
    keep_tick = 1'b0;
    for (int j = 0; j < KAL; j++) step();
    chk("R5 last alive edge", 2'b01, 1'b0);
    step();
    chk("R5 expired", 2'b00, 1'b0);
    auto_mode = 1'b0;
    step();
    chk("R5 manual ignores ticks", 2'b01, 1'b1);
    for (int j = 0; j < 2 * KAL; j++) step();
    chk("R10 gate follows run", 2'b01, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule